// File: doc/BRIEF.md
# Serial Gain Control Register

This block is the digital control front end of a programmable line amplifier. A host loads a gain word over three wires: an active-low load enable, a serial data line and a serial clock. While the enable is low, each rising serial clock edge shifts one data bit into an 8-bit shift register, most significant bit first. When the enable returns high, the shift register contents are copied into a holding latch. That latch drives the attenuator code.

The latched code is also decoded into two outputs. One is a step index, the position of the highest set bit; any code with the top bit set saturates to the top step. The other is an isolation flag for code zero. A separate asynchronous, active-low power-down input gates the forward-transmit enable directly, with no clock involved. All serial pins are resynchronised into the core clock domain. A shift or commit therefore takes effect a fixed few core cycles after the pin edge that caused it.

Top module: `gain_ctl_serial`

## Requirements
- R1: While the load enable `ld_en_n` is low, each rising edge of `ser_clk` shifts the level of `ser_dat` into bit 0 of the shift register and moves the older bits up by one. After eight edges, the first bit sent sits in bit 7 of the committed code.
- R2: While `ld_en_n` is low, `gain_code` keeps the previously committed value, however many bits are shifted.
- R3: A rising edge of `ld_en_n` copies the shift register into `gain_code` within SYNC_STAGES+2 core clock cycles and sets `code_valid` to 1.
- R4: Rising `ser_clk` edges that occur while `ld_en_n` is high change neither the shift register nor `gain_code`. A later commit shows the shift register unchanged.
- R5: No bits are counted. A commit after fewer than eight or more than eight bits latches the shift register exactly as it stands, and the shift register is not cleared when a new load begins.
- R6: `gain_step` equals the index (0 to 7) of the highest set bit of `gain_code`. Any code with bit 7 set gives step 7, whatever the lower bits are.
- R7: When `gain_code` is 0, `isolate` is 1 and `gain_step` is 0. For any nonzero code, `isolate` is 0.
- R8: `tx_en` equals `pwr_on` at all times, combinationally and without any core clock edge (0 = powered down, 1 = transmit), independent of the code and of `code_valid`.
- R9: After reset, `gain_code` is 0, `code_valid` is 0, `isolate` is 1, and the shift register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock used to sample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock; rising edge captures a bit |
| ld_en_n | input | 1 | Active-low load enable; rising edge commits the word |
| ser_dat | input | 1 | Serial data, most significant bit first |
| pwr_on | input | 1 | Asynchronous power control; 0 disables transmission |
| gain_code | output | 8 | Committed attenuator code |
| gain_step | output | 3 | Index of the highest set bit of the committed code |
| isolate | output | 1 | High when the committed code is zero |
| code_valid | output | 1 | Set by the first commit after reset |
| tx_en | output | 1 | Forward-transmit enable, follows pwr_on |

## Verification
The hardest state to reach from the ports is a shift register that holds leftover bits from earlier sequences. Partial loads, overlong loads and clock pulses sent while the enable is high all leave such bits behind, and only the next commit reveals them. The bench keeps its own model of the shift register across every sequence. Random sequences of random length are mixed with ignored clock bursts and directed loads of zero, of saturating codes and of non-power-of-two codes. Each commit is then compared with the model.

// File: rtl/gain_ctl_serial.sv
`timescale 1ns/1ps
module gain_ctl_serial #(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ser_clk,
  input  logic                       ld_en_n,
  input  logic                       ser_dat,
  input  logic                       pwr_on,
  output logic [WORD_W-1:0]          gain_code,
  output logic [$clog2(WORD_W)-1:0]  gain_step,
  output logic                       isolate,
  output logic                       code_valid,
  output logic                       tx_en
);
  localparam int STEP_W = $clog2(WORD_W);

  logic [SYNC_STAGES-1:0] ck_sy, en_sy, dt_sy;
  logic ck_d, en_d;
  logic [WORD_W-1:0] shreg, lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sy <= '0;
      en_sy <= '1;
      dt_sy <= '0;
      ck_d  <= 1'b0;
      en_d  <= 1'b1;
    end else begin
      ck_sy <= {ck_sy[SYNC_STAGES-2:0], ser_clk};
      en_sy <= {en_sy[SYNC_STAGES-2:0], ld_en_n};
      dt_sy <= {dt_sy[SYNC_STAGES-2:0], ser_dat};
      ck_d  <= ck_sy[SYNC_STAGES-1];
      en_d  <= en_sy[SYNC_STAGES-1];
    end
  end

  wire ck_s   = ck_sy[SYNC_STAGES-1];
  wire en_s   = en_sy[SYNC_STAGES-1];
  wire dt_s   = dt_sy[SYNC_STAGES-1];
  wire shift  = ck_s & ~ck_d & ~en_s;
  wire commit = en_s & ~en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shreg <= '0;
    else if (shift) shreg <= {shreg[WORD_W-2:0], dt_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat        <= '0;
      code_valid <= 1'b0;
    end else if (commit) begin
      lat        <= shreg;
      code_valid <= 1'b1;
    end
  end

  always_comb begin
    gain_step = '0;
    for (int i = 0; i < WORD_W; i++)
      if (lat[i]) gain_step = STEP_W'(i);
  end

  assign gain_code = lat;
  assign isolate   = (lat == '0);
  assign tx_en     = pwr_on;

  p_hold_while_loading_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> $stable(lat));
  p_ignore_idle_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_s |=> $stable(shreg));
  p_saturate_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gain_code[WORD_W-1] |-> gain_step == STEP_W'(WORD_W-1));
  p_isolate_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    isolate |-> gain_step == '0);
  p_unprogrammed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !code_valid |-> gain_code == '0);
  p_valid_sticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |=> code_valid);
endmodule

// File: tb/gain_ctl_serial_tb.sv
`timescale 1ns/1ps
module gain_ctl_serial_tb;
  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ld_en_n = 1, ser_dat = 0, pwr_on = 0;
  logic [7:0] gain_code;
  logic [2:0] gain_step;
  logic isolate, code_valid, tx_en;
  int checks = 0, fails = 0;
  logic [7:0] m_sh = 0, m_lat = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gain_ctl_serial u_dut (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ld_en_n(ld_en_n),
    .ser_dat(ser_dat), .pwr_on(pwr_on), .gain_code(gain_code), .gain_step(gain_step),
    .isolate(isolate), .code_valid(code_valid), .tx_en(tx_en));

  function automatic logic [2:0] f_step(logic [7:0] c);
    logic [2:0] s = 0;
    for (int i = 0; i < 8; i++) if (c[i]) s = 3'(i);
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send_bit(logic b, bit counted);
    ser_dat = b; wclk(3);
    ser_clk = 1; wclk(3);
    ser_clk = 0; wclk(3);
    if (counted) m_sh = {m_sh[6:0], b};
  endtask

  task automatic start_load();
    ld_en_n = 0; wclk(4);
  endtask

  task automatic commit_and_check(string req);
    ld_en_n = 1; wclk(6);
    m_lat = m_sh;
    chk({req, " code"}, gain_code, m_lat);
    chk("R6 step", gain_step, f_step(m_lat));
    chk("R7 isolate", isolate, m_lat == 0);
    chk("R3 valid", code_valid, 1);
  endtask

  task automatic load_word(logic [7:0] w, int nbits, string req);
    start_load();
    for (int i = nbits - 1; i >= 0; i--) send_bit(w[i % 8], 1);
    commit_and_check(req);
  endtask

  initial begin
    void'($urandom(32'd1234));
    wclk(3);
    chk("R9 code", gain_code, 0);
    chk("R9 valid", code_valid, 0);
    chk("R9 isolate", isolate, 1);
    chk("R8 txen", tx_en, 0);
    rst_n = 1; wclk(2);
    pwr_on = 1; #1;
    chk("R8 txen async", tx_en, 1);
    pwr_on = 0; #1;
    chk("R8 txen async", tx_en, 0);
    // R4: clock pulses with enable high before any load
    for (int i = 0; i < 5; i++) send_bit(1, 0);
    chk("R4 idle code", gain_code, 0);
    chk("R4 idle valid", code_valid, 0);
    // R1 MSB first
    load_word(8'h01, 8, "R1");
    load_word(8'h40, 8, "R1");
    load_word(8'hB5, 8, "R6");
    load_word(8'h00, 8, "R7");
    load_word(8'h06, 8, "R6");
    // R2: partial shifting keeps old gain
    start_load();
    for (int i = 0; i < 5; i++) begin
      send_bit(1, 1);
      chk("R2 hold", gain_code, m_lat);
    end
    commit_and_check("R5 partial");
    // R4: ignored pulses then zero-bit commit shows shreg unchanged
    for (int i = 0; i < 4; i++) send_bit(0, 0);
    chk("R4 ignored", gain_code, m_lat);
    start_load();
    commit_and_check("R4 empty");
    // overlong word
    load_word(8'h5A, 11, "R5 long");
    for (int it = 0; it < 60; it++) begin
      int n = $urandom_range(10, 0);
      logic [7:0] w = 8'($urandom);
      if ($urandom_range(3, 0) == 0) send_bit(1'($urandom), 0);
      pwr_on = 1'($urandom); #1;
      chk("R8 txen", tx_en, pwr_on);
      start_load();
      for (int i = 0; i < n; i++) begin
        send_bit(w[i % 8], 1);
        if (i == 0) chk("R2 hold", gain_code, m_lat);
      end
      commit_and_check("R3 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule